// File: doc/BRIEF.md
# Address Translation Buffer with Page-Table Refill

This block sits in a processor's memory stage and turns virtual addresses into physical ones. A small fully associative buffer holds recent page translations. Each one is tagged with the virtual page number and the process ID that owns it. On a hit the physical address comes back combinationally in the same cycle. The 12-bit page offset passes through untouched.

On a miss the block raises `busy` and walks a single-level page table. It reads one 32-bit entry from memory at the table base plus four times the virtual page number, then loads the translation into a free or victim slot. The requester holds its request steady until `busy` falls. After that the access either hits or reports a page fault.

The block enforces read-only against read-write permission on stores. It records reference and dirty state per entry. Software controls are a flush input that invalidates all entries on a context switch and a clear input that drops all reference bits.

Top module: `xlate_unit`

## Requirements
- R1: After reset no lookup hits, `busy`, both fault outputs and `mem_req_valid` are low, and the table base is 0, so the first walk reads address 4×VPN.
- R2: A lookup hits only when a valid entry matches both the virtual page number (address bits 31:12) and `cur_pid`. On a hit `resp_hit` is high in the same cycle and `resp_paddr` is {PPN, vaddr[11:0]}.
- R3: A lookup that misses raises `busy` in the same cycle and causes one memory read at base + 4×VPN. `mem_req_valid` and `mem_req_addr` stay steady until `mem_req_ready` is seen.
- R4: If the returned entry has bit 31 (valid) and bit 30 (resident) set, the translation is loaded with PPN from bits 19:0 and write permission from bit 29, and the held lookup hits in the cycle after the response.
- R5: If the entry has bit 31 or bit 30 clear, `fault_page` pulses for one cycle with `busy` and `resp_hit` low, and nothing is loaded, so a repeated access misses again.
- R6: A store that matches an entry whose write bit is clear raises `fault_prot` and does not hit. Loads to the same page hit.
- R7: `resp_dirty` reports on a hit whether any earlier store has hit that entry since it was loaded.
- R8: The same virtual page under a different process ID misses and is walked separately.
- R9: A one-cycle `flush` invalidates every entry.
- R10: Refill goes to the lowest-indexed invalid entry if one exists. Otherwise it goes to the lowest-indexed entry whose reference bit is clear, and otherwise to entry 0. Reference bits are set on a fill and on every permitted hit.
- R11: A one-cycle `ref_clear` clears every reference bit.
- R12: A one-cycle `base_wr` loads `base_wdata` as the table base used by later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request, held while busy |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| cur_pid | input | 8 | Current process ID |
| base_wr | input | 1 | Write the page-table base |
| base_wdata | input | 32 | New page-table base |
| flush | input | 1 | Invalidate all entries |
| ref_clear | input | 1 | Clear all reference bits |
| resp_hit | output | 1 | Permitted translation available |
| resp_paddr | output | 32 | Physical address on a hit |
| resp_dirty | output | 1 | Dirty state of the hit entry |
| busy | output | 1 | Lookup stalled for a refill |
| fault_page | output | 1 | Unmapped or non-resident page |
| fault_prot | output | 1 | Store to read-only page |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_addr | output | 32 | Page-table entry address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_data | input | 32 | Page-table entry |

## Verification
Every cycle the assertions check that at most one entry matches a lookup and that the read request holds steady until accepted. They also check that a page fault is a single quiet pulse, that a flush empties the table, that a reference clear takes effect, and that a refill never overwrites a valid entry while an invalid one is free. Only the bench's scenarios show the translated addresses and the walk addresses built from the base register. The same holds for which translation survives an eviction under each reference-bit pattern, process-ID separation, and dirty reporting after stores.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = 20;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int PTE_W = 32;
  localparam int PTE_VLD = 31;
  localparam int PTE_RES = 30;
  localparam int PTE_WR  = 29;

  typedef enum logic [1:0] {WK_IDLE, WK_REQ, WK_WAIT, WK_FLT} walk_state_e;

  // entry address = base + 4 * vpn
  function automatic logic [PA_W-1:0] pte_addr(input logic [PA_W-1:0] base,
                                                input logic [VPN_W-1:0] vpn);
    return base + PA_W'({vpn, 2'b00});
  endfunction

  function automatic logic pte_usable(input logic [PTE_W-1:0] pte);
    return pte[PTE_VLD] & pte[PTE_RES];
  endfunction
endpackage

// File: rtl/xlate_victim.sv
module xlate_victim #(
  parameter int N_ENT = 2
) (
  input  logic [N_ENT-1:0] valid,
  input  logic [N_ENT-1:0] ref_bits,
  output logic [N_ENT-1:0] sel
);
  logic found;
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!found && !valid[i]) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
    for (int i = 0; i < N_ENT; i++) begin
      if (!found && !ref_bits[i]) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
    if (!found) sel[0] = 1'b1;
  end
endmodule

// File: rtl/xlate_table.sv
module xlate_table import xlate_pkg::*; #(
  parameter int N_ENT = 2,
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic [PID_W-1:0] look_pid,
  input  logic             touch_en,
  input  logic             dirty_en,
  input  logic             flush,
  input  logic             ref_clear,
  input  logic             fill_en,
  input  logic [N_ENT-1:0] fill_sel,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_wr,
  output logic [N_ENT-1:0] match,
  output logic [PPN_W-1:0] hit_ppn,
  output logic             hit_wr,
  output logic             hit_dirty,
  output logic [N_ENT-1:0] valid_o,
  output logic [N_ENT-1:0] ref_o
);
  logic [N_ENT-1:0] valid_q, ref_q, dirty_q, wr_q;
  logic [VPN_W-1:0] vpn_q [N_ENT];
  logic [PID_W-1:0] pid_q [N_ENT];
  logic [PPN_W-1:0] ppn_q [N_ENT];

  always_comb begin
    hit_ppn   = '0;
    hit_wr    = 1'b0;
    hit_dirty = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      match[i] = valid_q[i] && (vpn_q[i] == look_vpn) && (pid_q[i] == look_pid);
      if (match[i]) begin
        hit_ppn   = hit_ppn | ppn_q[i];
        hit_wr    = hit_wr | wr_q[i];
        hit_dirty = hit_dirty | dirty_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
      wr_q    <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        vpn_q[i] <= '0;
        pid_q[i] <= '0;
        ppn_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (flush) valid_q[i] <= 1'b0;
        else if (fill_en && fill_sel[i]) valid_q[i] <= 1'b1;
        if (fill_en && fill_sel[i]) begin
          vpn_q[i]   <= fill_vpn;
          pid_q[i]   <= fill_pid;
          ppn_q[i]   <= fill_ppn;
          wr_q[i]    <= fill_wr;
          dirty_q[i] <= 1'b0;
        end else if (dirty_en && match[i]) begin
          dirty_q[i] <= 1'b1;
        end
        if ((fill_en && fill_sel[i]) || (touch_en && match[i])) ref_q[i] <= 1'b1;
        else if (ref_clear) ref_q[i] <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign ref_o   = ref_q;

  p_match_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
  p_fill_takes_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(&valid_q)) |-> ((fill_sel & valid_q) == '0));
  p_ref_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_clear && !fill_en && !touch_en) |=> (ref_q == '0));
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker import xlate_pkg::*; #(
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VPN_W-1:0] start_vpn,
  input  logic [PID_W-1:0] start_pid,
  input  logic [PA_W-1:0]  base,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_req_ready,
  input  logic             mem_resp_valid,
  input  logic [PTE_W-1:0] mem_resp_data,
  output logic             idle,
  output logic             walking,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PID_W-1:0] fill_pid,
  output logic [PPN_W-1:0] fill_ppn,
  output logic             fill_wr,
  output logic             fault_page
);
  walk_state_e state_q;
  logic [PA_W-1:0]  addr_q;
  logic             resp_evt;
  logic             unused_pte_bits;

  assign unused_pte_bits = ^mem_resp_data[PTE_WR-1:PPN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WK_IDLE;
      addr_q   <= '0;
      fill_vpn <= '0;
      fill_pid <= '0;
    end else begin
      case (state_q)
        WK_IDLE: if (start) begin
          state_q  <= WK_REQ;
          addr_q   <= pte_addr(base, start_vpn);
          fill_vpn <= start_vpn;
          fill_pid <= start_pid;
        end
        WK_REQ:  if (mem_req_ready) state_q <= WK_WAIT;
        WK_WAIT: if (mem_resp_valid)
                   state_q <= pte_usable(mem_resp_data) ? WK_IDLE : WK_FLT;
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign resp_evt      = (state_q == WK_WAIT) && mem_resp_valid;
  assign fill_en       = resp_evt && pte_usable(mem_resp_data);
  assign fill_ppn      = mem_resp_data[PPN_W-1:0];
  assign fill_wr       = mem_resp_data[PTE_WR];
  assign fault_page    = (state_q == WK_FLT);
  assign mem_req_valid = (state_q == WK_REQ);
  assign mem_req_addr  = addr_q;
  assign idle          = (state_q == WK_IDLE);
  assign walking       = (state_q == WK_REQ) || (state_q == WK_WAIT);

  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  p_fault_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_page |=> !fault_page);
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit import xlate_pkg::*; #(
  parameter int N_ENT = 2,
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  input  logic [PID_W-1:0] cur_pid,
  input  logic             base_wr,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             flush,
  input  logic             ref_clear,
  output logic             resp_hit,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             resp_dirty,
  output logic             busy,
  output logic             fault_page,
  output logic             fault_prot,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_req_ready,
  input  logic             mem_resp_valid,
  input  logic [PTE_W-1:0] mem_resp_data
);
  logic [PA_W-1:0]  base_q;
  logic [VPN_W-1:0] look_vpn;
  logic [N_ENT-1:0] match, valid_bits, ref_bits, victim_sel;
  logic [PPN_W-1:0] hit_ppn, fill_ppn;
  logic [VPN_W-1:0] fill_vpn;
  logic [PID_W-1:0] fill_pid;
  logic hit_wr, hit_dirty, fill_en, fill_wr;
  logic walk_idle, walking;
  logic lookup_en, any_hit, prot_evt, miss_evt, hit_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (base_wr) base_q <= base_wdata;
  end

  assign look_vpn  = req_vaddr[VA_W-1:OFF_W];
  assign lookup_en = req_valid && walk_idle;
  assign any_hit   = |match;
  assign prot_evt  = lookup_en && any_hit && req_store && !hit_wr;
  assign hit_evt   = lookup_en && any_hit && !prot_evt;
  assign miss_evt  = lookup_en && !any_hit;

  xlate_table #(.N_ENT(N_ENT), .PID_W(PID_W)) u_table (
    .clk(clk), .rst_n(rst_n), .look_vpn(look_vpn), .look_pid(cur_pid),
    .touch_en(hit_evt), .dirty_en(hit_evt && req_store),
    .flush(flush), .ref_clear(ref_clear),
    .fill_en(fill_en), .fill_sel(victim_sel), .fill_vpn(fill_vpn),
    .fill_pid(fill_pid), .fill_ppn(fill_ppn), .fill_wr(fill_wr),
    .match(match), .hit_ppn(hit_ppn), .hit_wr(hit_wr), .hit_dirty(hit_dirty),
    .valid_o(valid_bits), .ref_o(ref_bits));

  xlate_victim #(.N_ENT(N_ENT)) u_victim (
    .valid(valid_bits), .ref_bits(ref_bits), .sel(victim_sel));

  xlate_walker #(.PID_W(PID_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .start(miss_evt), .start_vpn(look_vpn),
    .start_pid(cur_pid), .base(base_q),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data), .idle(walk_idle), .walking(walking),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
    .fill_ppn(fill_ppn), .fill_wr(fill_wr), .fault_page(fault_page));

  assign resp_hit   = hit_evt;
  assign resp_paddr = {hit_ppn, req_vaddr[OFF_W-1:0]};
  assign resp_dirty = hit_evt && hit_dirty;
  assign fault_prot = prot_evt;
  assign busy       = miss_evt || walking;

  p_fault_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_page |-> (!resp_hit && !busy));
  p_walk_after_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(busy));
endmodule

// File: tb/test_xlate_unit.sv
`timescale 1ns/1ps
module test_xlate_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, base_wr = 0, flush = 0, ref_clear = 0;
  logic [31:0] req_vaddr = 0, base_wdata = 0, mem_resp_data = 0;
  logic [7:0]  cur_pid = 0;
  logic mem_req_ready = 0, mem_resp_valid = 0;
  logic resp_hit, resp_dirty, busy, fault_page, fault_prot, mem_req_valid;
  logic [31:0] resp_paddr, mem_req_addr;
  int vectors = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  xlate_unit i_xlate_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_store(req_store), .cur_pid(cur_pid), .base_wr(base_wr),
    .base_wdata(base_wdata), .flush(flush), .ref_clear(ref_clear),
    .resp_hit(resp_hit), .resp_paddr(resp_paddr), .resp_dirty(resp_dirty),
    .busy(busy), .fault_page(fault_page), .fault_prot(fault_prot),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data));

  localparam logic [31:0] V = 32'h8000_0000, RS = 32'h4000_0000, W = 32'h2000_0000;

  function automatic logic [31:0] walk_addr(input logic [31:0] b, input logic [31:0] va);
    return b + ((va >> 12) * 4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic st, input logic [7:0] pid,
                      input logic e_hit, input logic [31:0] e_pa, input logic e_busy,
                      input logic e_prot, input logic e_dirty, input string tag);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_store = st; cur_pid = pid;
    #1;
    check({tag, " hit"}, resp_hit, e_hit);
    check({tag, " busy"}, busy, e_busy);
    check({tag, " prot"}, fault_prot, e_prot);
    if (e_hit) begin
      check({tag, " paddr"}, resp_paddr, e_pa);
      check({tag, " dirty"}, resp_dirty, e_dirty);
    end
  endtask

  task automatic serve(input logic [31:0] e_addr, input logic [31:0] pte,
                       input logic e_fault, input logic [31:0] e_pa, input string tag);
    int n = 0;
    @(negedge clk);
    while (!mem_req_valid && n < 20) begin @(negedge clk); n++; end
    check({tag, " R3 walk addr"}, mem_req_addr, e_addr);
    @(negedge clk);
    check({tag, " R3 req held"}, {31'b0, mem_req_valid}, 1);
    check({tag, " R3 addr held"}, mem_req_addr, e_addr);
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0; mem_resp_valid = 1; mem_resp_data = pte;
    @(negedge clk);
    mem_resp_valid = 0;
    #1;
    check({tag, " R5 fault_page"}, fault_page, e_fault);
    check({tag, " R4 hit after refill"}, resp_hit, !e_fault);
    check({tag, " busy after resolve"}, busy, 0);
    if (!e_fault) check({tag, " R4 paddr"}, resp_paddr, e_pa);
  endtask

  task automatic drop();
    @(negedge clk);
    req_valid = 0; req_store = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) flush = 1; else ref_clear = 1;
    @(negedge clk);
    flush = 0; ref_clear = 0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset hit", resp_hit, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset memreq", mem_req_valid, 0);
    check("R1 reset faults", {fault_page, fault_prot}, 0);
  endtask

  task automatic t_first_walk();
    look(32'h0000_3ABC, 0, 8'd1, 0, 0, 1, 0, 0, "R3 miss");
    serve(walk_addr(0, 32'h3ABC), V | RS | W | 32'h77, 0, 32'h0007_7ABC, "R1 base0");
    drop();
  endtask

  task automatic t_base();
    @(negedge clk); base_wr = 1; base_wdata = 32'h0001_0000;
    @(negedge clk); base_wr = 0;
    look(32'h0000_5010, 0, 8'd1, 0, 0, 1, 0, 0, "R12 miss");
    serve(32'h0001_0014, V | RS | 32'h123, 0, 32'h0012_3010, "R12 base");
    drop();
  endtask

  task automatic t_prot();
    look(32'h0000_5020, 1, 8'd1, 0, 0, 0, 1, 0, "R6 store ro");
    look(32'h0000_5020, 0, 8'd1, 1, 32'h0012_3020, 0, 0, 0, "R6 load ro");
    drop();
  endtask

  task automatic t_dirty();
    look(32'h0000_3000, 0, 8'd1, 1, 32'h0007_7000, 0, 0, 0, "R7 clean");
    look(32'h0000_3004, 1, 8'd1, 1, 32'h0007_7004, 0, 0, 0, "R7 store");
    look(32'h0000_3008, 0, 8'd1, 1, 32'h0007_7008, 0, 0, 1, "R7 dirty");
    drop();
  endtask

  task automatic t_pid_and_fault();
    look(32'h0000_3ABC, 0, 8'd2, 0, 0, 1, 0, 0, "R8 other pid");
    serve(32'h0001_000C, V | RS | W | 32'h999, 0, 32'h0099_9ABC, "R8 walk");
    drop();
    look(32'h0000_5000, 0, 8'd1, 1, 32'h0012_3000, 0, 0, 0, "R10 both ref evicts 0");
    look(32'h0000_3000, 0, 8'd1, 0, 0, 1, 0, 0, "R10 evicted entry");
    serve(32'h0001_000C, RS | W | 32'h5, 1, 0, "R5 unmapped");
    drop();
    look(32'h0000_3000, 0, 8'd1, 0, 0, 1, 0, 0, "R5 not loaded");
    serve(32'h0001_000C, V | 32'h55, 1, 0, "R5 not resident");
    drop();
  endtask

  task automatic t_ref();
    pulse(1);
    look(32'h0000_3000, 0, 8'd2, 1, 32'h0099_9000, 0, 0, 0, "R11 touch e0");
    look(32'h0000_7000, 0, 8'd1, 0, 0, 1, 0, 0, "R11 miss");
    serve(32'h0001_001C, V | RS | W | 32'h444, 0, 32'h0044_4000, "R11 walk");
    drop();
    look(32'h0000_3000, 0, 8'd2, 1, 32'h0099_9000, 0, 0, 0, "R10 referenced kept");
    look(32'h0000_5000, 0, 8'd1, 0, 0, 1, 0, 0, "R10 unreferenced evicted");
    serve(32'h0001_0014, 0, 1, 0, "R10 end walk");
    drop();
  endtask

  task automatic t_flush();
    pulse(0);
    look(32'h0000_3000, 0, 8'd2, 0, 0, 1, 0, 0, "R9 flushed");
    serve(32'h0001_000C, V | RS | W | 32'hABC, 0, 32'h00AB_C000, "R9 refill");
    drop();
    pulse(1);
    look(32'h0000_8000, 0, 8'd2, 0, 0, 1, 0, 0, "R10 miss");
    serve(32'h0001_0020, V | RS | 32'h321, 0, 32'h0032_1000, "R10 walk");
    drop();
    look(32'h0000_3000, 0, 8'd2, 1, 32'h00AB_C000, 0, 0, 0, "R10 invalid filled first");
    drop();
  endtask

  initial begin
    #20000;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_first_walk();
    t_base();
    t_prot();
    t_dirty();
    t_pid_and_fault();
    t_ref();
    t_flush();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule